// File: doc/BRIEF.md
# Three-Phase Logical Operation Unit

This block is the logical execution unit of an integer pipeline. It computes bitwise results from two operands under a small decoded control word, in three separable combinational phases. An input phase may complement operand A and chooses which carry value travels with the operation. A core phase knows only AND, OR and XOR. An output phase may complement the core result and derives a four-bit condition field from the final value. Complemented forms such as NAND, NOR, EQV and AND-with-complement are not separate operations: each is obtained by setting the complement controls around one of the three core functions.

Each phase is its own module, so that other pipeline stages can instantiate the same logic. One register stage with a valid/ready handshake holds the outputs. Decode and register-file access belong to the surrounding pipeline.

Control word layout (7 bits): bits [1:0] select the core function, bit 2 complements operand A, bit 3 complements the core result, bits [5:4] select the carry, bit 6 enables the condition field.

Top module: `logic_unit`

## Requirements
- R1: The core function follows ctrl[1:0]: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, and 11 gives all zeros before any output complement.
- R2: When ctrl[2] is 1, operand A is bit-complemented before the core function; when 0 it is used unchanged.
- R3: When ctrl[3] is 1, the core result is bit-complemented to form `result`; when 0 it passes unchanged.
- R4: `carry_out` follows ctrl[5:4]: 00 gives 0, 01 gives 1, 10 gives `carry_in`, 11 gives 0.
- R5: When ctrl[6] is 1, `cond` is {LT, GT, EQ, SO} in bits [3:0], with LT set when the final result is negative as a signed number, GT set when it is positive and nonzero, EQ set when it is zero; when ctrl[6] is 0, `cond` is 0000.
- R6: When ctrl[6] is 1, cond[0] equals the `so_in` input captured with the operation.
- R7: When `in_valid` and `out_ready` are both 1 at a rising clock edge, the outputs computed from the inputs present then appear after that edge with `out_valid` set to 1.
- R8: While `out_ready` is 0, `out_valid`, `result`, `carry_out` and `cond` hold their values whatever the inputs do, and `in_ready` is 0.
- R9: When `out_ready` is 1 and `in_valid` is 0 at a rising edge, `out_valid` is 0 after that edge; `in_ready` equals `out_ready`.
- R10: While `rst_n` is 0, `out_valid`, `result`, `carry_out` and `cond` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and control are valid |
| in_ready | output | 1 | Unit accepts an operation this cycle |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| ctrl | input | 7 | Decoded control word |
| carry_in | input | 1 | Stored carry bit |
| so_in | input | 1 | Summary-overflow bit for the condition field |
| out_valid | output | 1 | Registered outputs hold a result |
| out_ready | input | 1 | Consumer takes the registered result |
| result | output | 64 | Final logical result |
| carry_out | output | 1 | Selected carry |
| cond | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
Every one of the 128 control words is applied with operand pairs of all zeros, all ones, complementary alternating bit patterns, identical patterns and pseudo-random values, with the carry and summary-overflow inputs alternating. Zero and all-ones operands separate AND from OR and show each complement control on its own, while alternating and random pairs separate XOR from OR and catch swapped or shifted bits. Results with the sign bit set, clear, and all-zero drive each of the three comparison flags. Separate sequences stall the consumer with changing inputs and drain the register with no new operation to exercise the handshake.

// File: rtl/logic_unit_pkg.sv
package logic_unit_pkg;

   typedef enum logic [1:0] {
      CORE_AND  = 2'b00,
      CORE_OR   = 2'b01,
      CORE_XOR  = 2'b10,
      CORE_NONE = 2'b11
   } core_fn_e;

   typedef enum logic [1:0] {
      CSEL_ZERO  = 2'b00,
      CSEL_ONE   = 2'b01,
      CSEL_STORE = 2'b10,
      CSEL_RSVD  = 2'b11
   } carry_sel_e;

   typedef struct packed {
      logic       cond_en;
      carry_sel_e carry_sel;
      logic       flip_out;
      logic       flip_a;
      core_fn_e   fn;
   } lu_ctrl_t;

   localparam int unsigned CTRL_BITS = $bits(lu_ctrl_t);
   localparam int unsigned COND_BITS = 4;

endpackage

// File: rtl/lu_pre.sv
module lu_pre #(
   parameter int unsigned WIDTH = 64
) (
   input  logic [WIDTH-1:0]              a_in,
   input  logic                          flip_a,
   input  logic_unit_pkg::carry_sel_e    carry_sel,
   input  logic                          carry_store,
   output logic [WIDTH-1:0]              a_out,
   output logic                          carry_sel_out
);
   import logic_unit_pkg::*;

   if (WIDTH < 1) begin : g_bad_width
      $error("lu_pre: WIDTH must be at least 1");
   end

   assign a_out = flip_a ? ~a_in : a_in;

   always_comb begin
      unique case (carry_sel)
         CSEL_ZERO:  carry_sel_out = 1'b0;
         CSEL_ONE:   carry_sel_out = 1'b1;
         CSEL_STORE: carry_sel_out = carry_store;
         default:    carry_sel_out = 1'b0;
      endcase
   end

endmodule

// File: rtl/lu_core.sv
module lu_core #(
   parameter int unsigned WIDTH = 64
) (
   input  logic [WIDTH-1:0]            a,
   input  logic [WIDTH-1:0]            b,
   input  logic_unit_pkg::core_fn_e    fn,
   output logic [WIDTH-1:0]            y
);
   import logic_unit_pkg::*;

   if (WIDTH < 1) begin : g_bad_width
      $error("lu_core: WIDTH must be at least 1");
   end

   always_comb begin
      unique case (fn)
         CORE_AND: y = a & b;
         CORE_OR:  y = a | b;
         CORE_XOR: y = a ^ b;
         default:  y = '0;
      endcase
   end

endmodule

// File: rtl/lu_post.sv
module lu_post #(
   parameter int unsigned WIDTH  = 64,
   parameter int unsigned ZCHUNK = 8
) (
   input  logic [WIDTH-1:0] y_in,
   input  logic             flip_out,
   input  logic             cond_en,
   input  logic             so_in,
   output logic [WIDTH-1:0] y_out,
   output logic [3:0]       cond_out
);
   localparam int unsigned NCHUNK = WIDTH / ZCHUNK;

   if (WIDTH < 2) begin : g_bad_width
      $error("lu_post: WIDTH must be at least 2");
   end
   if (ZCHUNK == 0 || (WIDTH % ZCHUNK) != 0) begin : g_bad_chunk
      $error("lu_post: ZCHUNK must divide WIDTH");
   end

   logic [NCHUNK-1:0] chunk_nz;
   logic              is_zero;
   logic              is_neg;

   assign y_out = flip_out ? ~y_in : y_in;

   for (genvar c = 0; c < NCHUNK; c++) begin : g_zchunk
      assign chunk_nz[c] = |y_out[c*ZCHUNK +: ZCHUNK];
   end

   assign is_zero = ~|chunk_nz;
   assign is_neg  = y_out[WIDTH-1];

   always_comb begin
      if (cond_en) begin
         cond_out = {is_neg, ~is_neg & ~is_zero, is_zero, so_in};
      end else begin
         cond_out = 4'b0000;
      end
   end

endmodule

// File: rtl/lu_outreg.sv
module lu_outreg #(
   parameter int unsigned WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             out_ready,
   input  logic [WIDTH-1:0] d_result,
   input  logic             d_carry,
   input  logic [3:0]       d_cond,
   output logic             q_valid,
   output logic [WIDTH-1:0] q_result,
   output logic             q_carry,
   output logic [3:0]       q_cond
);
   logic take;
   assign take = in_valid & out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
      end else if (out_ready) begin
         q_valid <= in_valid;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_result <= '0;
         q_carry  <= 1'b0;
         q_cond   <= 4'b0000;
      end else if (take) begin
         q_result <= d_result;
         q_carry  <= d_carry;
         q_cond   <= d_cond;
      end
   end

endmodule

// File: rtl/logic_unit.sv
module logic_unit #(
   parameter int unsigned WIDTH  = 64,
   parameter int unsigned ZCHUNK = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [6:0]       ctrl,
   input  logic             carry_in,
   input  logic             so_in,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [WIDTH-1:0] result,
   output logic             carry_out,
   output logic [3:0]       cond
);
   import logic_unit_pkg::*;

   if (CTRL_BITS != 7) begin : g_bad_ctrl
      $error("logic_unit: control word layout must be 7 bits");
   end

   lu_ctrl_t          cw;
   logic [WIDTH-1:0]  a_pre;
   logic              carry_sel;
   logic [WIDTH-1:0]  y_core;
   logic [WIDTH-1:0]  y_post;
   logic [3:0]        cond_post;

   assign cw       = lu_ctrl_t'(ctrl);
   assign in_ready = out_ready;

   lu_pre #(.WIDTH(WIDTH)) u_pre (
      .a_in          (op_a),
      .flip_a        (cw.flip_a),
      .carry_sel     (cw.carry_sel),
      .carry_store   (carry_in),
      .a_out         (a_pre),
      .carry_sel_out (carry_sel)
   );

   lu_core #(.WIDTH(WIDTH)) u_core (
      .a  (a_pre),
      .b  (op_b),
      .fn (cw.fn),
      .y  (y_core)
   );

   lu_post #(.WIDTH(WIDTH), .ZCHUNK(ZCHUNK)) u_post (
      .y_in     (y_core),
      .flip_out (cw.flip_out),
      .cond_en  (cw.cond_en),
      .so_in    (so_in),
      .y_out    (y_post),
      .cond_out (cond_post)
   );

   lu_outreg #(.WIDTH(WIDTH)) u_oreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .out_ready (out_ready),
      .d_result  (y_post),
      .d_carry   (carry_sel),
      .d_cond    (cond_post),
      .q_valid   (out_valid),
      .q_result  (result),
      .q_carry   (carry_out),
      .q_cond    (cond)
   );

endmodule

// File: rtl/logic_unit_chk.sv
module logic_unit_chk #(
   parameter int unsigned WIDTH = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [WIDTH-1:0] result,
   input logic             carry_out,
   input logic [3:0]       cond
);

   // R7: an accepted operation is presented on the next cycle
   p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && out_ready) |=> out_valid);

   // R8: a stalled consumer sees stable outputs
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready |=> ($stable(out_valid) && $stable(result)
                      && $stable(carry_out) && $stable(cond)));

   // R9: draining with no new operation clears valid
   p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && out_ready) |=> !out_valid);

   // R5: at most one comparison flag is set
   p_cmp_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cond[3:1]));

   // R5: the equal flag only accompanies a zero result
   p_eq_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cond[1] |-> (result == '0));

   // R5: the less-than flag only accompanies a negative result
   p_lt_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cond[3] |-> result[WIDTH-1]);

endmodule

bind logic_unit logic_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .result    (result),
   .carry_out (carry_out),
   .cond      (cond)
);

// File: tb/logic_unit_bench.sv
module logic_unit_bench;
   localparam int W     = 64;
   localparam int CLK_P = 10;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic         in_ready;
   logic [W-1:0] op_a, op_b;
   logic [6:0]   ctrl;
   logic         carry_in, so_in;
   logic         out_valid;
   logic         out_ready;
   logic [W-1:0] result;
   logic         carry_out;
   logic [3:0]   cond;

   int n_vec  = 0;
   int n_fail = 0;

   logic [W-1:0] exp_res;
   logic         exp_cy;
   logic [3:0]   exp_cond;

   always #(CLK_P/2) clk = ~clk;

   logic_unit u_logic_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .op_a(op_a), .op_b(op_b), .ctrl(ctrl), .carry_in(carry_in),
      .so_in(so_in), .out_valid(out_valid), .out_ready(out_ready),
      .result(result), .carry_out(carry_out), .cond(cond)
   );

   task automatic chk1(input string req, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%b exp=%b", req, act, exp);
      end
   endtask

   task automatic model(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [6:0] c, input logic ci, input logic so);
      logic [W-1:0] aa, y;
      aa = c[2] ? ~a : a;
      case (c[1:0])
         2'b00:   y = aa & b;
         2'b01:   y = aa | b;
         2'b10:   y = aa ^ b;
         default: y = '0;
      endcase
      exp_res = c[3] ? ~y : y;
      case (c[5:4])
         2'b01:   exp_cy = 1'b1;
         2'b10:   exp_cy = ci;
         default: exp_cy = 1'b0;
      endcase
      if (c[6])
         exp_cond = {exp_res[W-1], !exp_res[W-1] && (exp_res != '0),
                     exp_res == '0, so};
      else
         exp_cond = 4'b0000;
   endtask

   task automatic check_outputs(input logic [6:0] c);
      n_vec++;
      if (out_valid !== 1'b1 || result !== exp_res || carry_out !== exp_cy
          || cond !== exp_cond) begin
         n_fail++;
         if (result !== exp_res)
            $display("FAIL R1 R2 R3 ctrl=%b result act=%h exp=%h", c, result, exp_res);
         if (carry_out !== exp_cy)
            $display("FAIL R4 ctrl=%b carry act=%b exp=%b", c, carry_out, exp_cy);
         if (cond !== exp_cond)
            $display("FAIL R5 R6 ctrl=%b cond act=%b exp=%b", c, cond, exp_cond);
         if (out_valid !== 1'b1)
            $display("FAIL R7 out_valid act=%b exp=1", out_valid);
      end
   endtask

   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [6:0] c, input logic ci, input logic so);
      @(negedge clk);
      op_a = a; op_b = b; ctrl = c; carry_in = ci; so_in = so;
      in_valid = 1'b1; out_ready = 1'b1;
      model(a, b, c, ci, so);
      @(negedge clk);
      check_outputs(c);
   endtask

   initial begin
      #(CLK_P * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      logic [W-1:0] pa [10];
      logic [W-1:0] pb [10];
      logic [W-1:0] lfsr;
      logic [W-1:0] held_res;

      rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
      op_a = '0; op_b = '0; ctrl = '0; carry_in = 1'b0; so_in = 1'b0;

      // R10: reset state
      @(negedge clk);
      chk1("R10 out_valid", out_valid, 1'b0);
      chk1("R10 result", |result, 1'b0);
      chk1("R10 carry", carry_out, 1'b0);
      chk1("R10 cond", |cond, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      pa[0] = '0;            pb[0] = '0;
      pa[1] = '1;            pb[1] = '0;
      pa[2] = '0;            pb[2] = '1;
      pa[3] = '1;            pb[3] = '1;
      pa[4] = {32{2'b10}};   pb[4] = {32{2'b01}};
      pa[5] = {32{2'b10}};   pb[5] = {32{2'b10}};
      lfsr = 64'h9E37_79B9_7F4A_7C15;
      for (int k = 6; k < 10; k++) begin
         lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
         pa[k] = lfsr ^ 64'h0123_4567_89AB_CDEF;
         lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
         pb[k] = {lfsr[31:0], lfsr[63:32]};
      end

      // R1 R2 R3 R4 R5 R6 R7: full control sweep over operand patterns
      for (int p = 0; p < 10; p++) begin
         for (int c = 0; c < 128; c++) begin
            apply(pa[p], pb[p], 7'(c), c[0] ^ p[0], c[1] ^ p[1]);
         end
      end

      // R1 R3: named complemented forms on random data (NAND, NOR, EQV, AND with complement)
      apply(pa[7], pb[7], 7'b1_00_1_0_00, 1'b0, 1'b0);
      chk1("R3 NAND", result === ~(pa[7] & pb[7]), 1'b1);
      apply(pa[7], pb[7], 7'b1_00_1_0_01, 1'b0, 1'b0);
      chk1("R3 NOR", result === ~(pa[7] | pb[7]), 1'b1);
      apply(pa[8], pb[8], 7'b1_00_1_0_10, 1'b0, 1'b0);
      chk1("R3 EQV", result === ~(pa[8] ^ pb[8]), 1'b1);
      apply(pa[8], pb[8], 7'b1_00_0_1_00, 1'b0, 1'b0);
      chk1("R2 ANDC", result === (~pa[8] & pb[8]), 1'b1);

      // R8: stall with changing inputs
      held_res = result;
      @(negedge clk);
      out_ready = 1'b0; in_valid = 1'b1;
      op_a = pa[9]; op_b = pb[9]; ctrl = 7'b1_01_0_0_01;
      chk1("R8 in_ready low", in_ready, 1'b0);
      @(negedge clk);
      op_a = pa[6]; ctrl = 7'b0_10_1_1_10;
      @(negedge clk);
      chk1("R8 valid held", out_valid, 1'b1);
      chk1("R8 result held", result === held_res, 1'b1);

      // R9: drain with no new operation
      out_ready = 1'b1; in_valid = 1'b0;
      chk1("R9 in_ready follows", in_ready, 1'b1);
      @(negedge clk);
      chk1("R9 valid cleared", out_valid, 1'b0);
      chk1("R9 result kept", result === held_res, 1'b1);
      @(negedge clk);
      chk1("R9 stays idle", out_valid, 1'b0);

      // R7: accept again after drain
      apply(pa[9], pb[9], 7'b1_10_0_0_10, 1'b1, 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule